// File: doc/BRIEF.md
# Power Management Event and Timer Register Block

This block holds the event status, event enable and power control registers of a platform power management unit, together with a free-running 24-bit timer that counts at 3.579545 MHz. Software reaches everything through a small I/O-style request port that carries byte, word and dword accesses. Hardware event sources pulse lines on `evt_in` to latch status flags. Software clears a flag by writing a one to it.

The timer tick comes from a phase accumulator clocked by the system clock, so no second clock domain is needed. When the count passes its top value it returns to zero and latches the timer overflow flag. The interrupt request output is the OR of every status flag that has its matching enable bit set, gated by the interrupt enable bit of the control register.

Top module: `pm_event_timer`

## Requirements
- R1: After reset, status reads 0x0000, enable reads 0x0000, control reads 0x0001, the timer reads 0 or 1, and `irq` is low.
- R2: The timer advances once per tick, and the long-run tick rate is 3.579545 MHz derived from `CLK_HZ`. Over 10000 cycles at 100 MHz it advances by 357 or 358.
- R3: When the count is 0xFFFFFF and a tick occurs, the count becomes 0 and status bit 0 (timer overflow) is set.
- R4: A dword write at offset 8 loads the timer from bits 23:0. Counting resumes from that value. A dword read at offset 8 returns the count with bits 31:24 zero. A word or byte write at offset 8 has no effect.
- R5: Status (offset 0) implements bits 0, 4, 5, 8, 10, 11 and 15, and all other bits read 0. A high `evt_in` bit sets the matching implemented bit. Writing 1 clears a bit and writing 0 leaves it unchanged. If a set and a clear hit the same bit in the same cycle, the set wins.
- R6: Enable (offset 2) stores bits 0, 5, 8 and 10. All other bits read 0.
- R7: Control (offset 4) stores bit 0 (interrupt enable), bit 2, bits 12:10 (sleep type) and bit 13. All other bits read 0.
- R8: Size code 0 is a byte access. Its data travels in bits 7:0, and an odd offset selects bits 15:8 of the register, leaving bits 7:0 untouched. Size code 1 is a word access at an even offset.
- R9: Size code 2 at offset 0 reads status in bits 15:0 and enable in bits 31:16. A write with this size and offset clears status bits from bits 15:0 (write one to clear) and writes enable from bits 31:16.
- R10: `irq` is high one cycle after any status bit is set together with its enable bit while control bit 0 is 1. It is low one cycle after that condition ends.
- R11: `rsp_valid` pulses for one cycle, one cycle after each read request, with the data on `rsp_rdata`. A misaligned access, or an access that runs past offset 11, reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset in the register map |
| req_size | input | 2 | 0 byte, 1 word, 2 dword |
| req_wdata | input | 32 | Write data, right-aligned for byte and word |
| evt_in | input | 16 | Hardware event pulses that set status bits |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, right-aligned |
| irq | output | 1 | Registered interrupt request |

## Verification
The checker assumes that the tick increment is below half the accumulator range, so two ticks never arrive on back-to-back cycles. It also assumes that a timer load and a tick are the only things that move the count. The rate properties rely on `CLK_HZ` being well above 3.579545 MHz, and the bench keeps the default 100 MHz. Random stimulus writes status only with word accesses and changes enable and control only through accesses of legal size. It is kept short, so the timer cannot wrap by accident while the status model runs.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10
  } acc_size_e;

  localparam int REG_W = 16;
  localparam logic [REG_W-1:0] STS_IMPL  = 16'h8D31;
  localparam logic [REG_W-1:0] EN_IMPL   = 16'h0521;
  localparam logic [REG_W-1:0] CTRL_IMPL = 16'h3C05;
  localparam logic [REG_W-1:0] CTRL_RST  = 16'h0001;
  localparam int TMR_OVF_BIT = 0;
  localparam int INT_EN_BIT  = 0;
endpackage

// File: rtl/pm_bus_decode.sv
module pm_bus_decode
  import pm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int TMR_W  = 24
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [1:0]        sts_we,
  output logic [1:0]        en_we,
  output logic [1:0]        ctrl_we,
  output logic [REG_W-1:0]  sts_d,
  output logic [REG_W-1:0]  en_d,
  output logic [REG_W-1:0]  ctrl_d,
  output logic              tmr_load,
  output logic [TMR_W-1:0]  tmr_d
);
  logic             wr_go;
  logic [REG_W-1:0] low_form;

  assign wr_go = req_valid && req_write;

  always_comb begin
    sts_we   = '0;
    en_we    = '0;
    ctrl_we  = '0;
    tmr_load = 1'b0;
    if (wr_go) begin
      unique case (acc_size_e'(req_size))
        SZ_BYTE: begin
          case (req_addr)
            ADDR_W'(0): sts_we  = 2'b01;
            ADDR_W'(1): sts_we  = 2'b10;
            ADDR_W'(2): en_we   = 2'b01;
            ADDR_W'(3): en_we   = 2'b10;
            ADDR_W'(4): ctrl_we = 2'b01;
            ADDR_W'(5): ctrl_we = 2'b10;
            default: ;
          endcase
        end
        SZ_WORD: begin
          case (req_addr)
            ADDR_W'(0): sts_we  = 2'b11;
            ADDR_W'(2): en_we   = 2'b11;
            ADDR_W'(4): ctrl_we = 2'b11;
            default: ;
          endcase
        end
        SZ_DWORD: begin
          case (req_addr)
            ADDR_W'(0): begin
              sts_we = 2'b11;
              en_we  = 2'b11;
            end
            ADDR_W'(8): tmr_load = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign low_form = (acc_size_e'(req_size) == SZ_BYTE) ?
                    {req_wdata[7:0], req_wdata[7:0]} : req_wdata[REG_W-1:0];
  assign sts_d  = low_form;
  assign ctrl_d = low_form;
  assign en_d   = (acc_size_e'(req_size) == SZ_DWORD) ?
                  req_wdata[2*REG_W-1:REG_W] : low_form;
  assign tmr_d  = req_wdata[TMR_W-1:0];
endmodule

// File: rtl/pm_tick_gen.sv
module pm_tick_gen #(
  parameter longint unsigned CLK_HZ  = 100_000_000,
  parameter longint unsigned TICK_HZ = 3_579_545,
  parameter int              ACC_W   = 32
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam longint unsigned INC64 =
    ((TICK_HZ << ACC_W) + (CLK_HZ / 2)) / CLK_HZ;
  localparam logic [ACC_W-1:0] INC = INC64[ACC_W-1:0];

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc_q} + {1'b0, INC};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      acc_q <= acc_sum[ACC_W-1:0];
      tick  <= acc_sum[ACC_W];
    end
  end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_en,
  input  logic [TMR_W-1:0] load_val,
  output logic [TMR_W-1:0] count,
  output logic             wrap
);
  assign wrap = tick && !load_en && (&count);

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (load_en) count <= load_val;
    else if (tick)    count <= count + TMR_W'(1);
  end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sts_we,
  input  logic [1:0]       en_we,
  input  logic [1:0]       ctrl_we,
  input  logic [REG_W-1:0] sts_d,
  input  logic [REG_W-1:0] en_d,
  input  logic [REG_W-1:0] ctrl_d,
  input  logic [REG_W-1:0] hw_set,
  output logic [REG_W-1:0] sts_q,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] ctrl_q,
  output logic             irq
);
  localparam int LANES = REG_W / 8;

  logic [REG_W-1:0] sts_nx, en_nx, ctrl_nx;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign sts_nx[8*b +: 8]  = sts_we[b]  ? (sts_q[8*b +: 8] & ~sts_d[8*b +: 8])
                                          : sts_q[8*b +: 8];
    assign en_nx[8*b +: 8]   = en_we[b]   ? en_d[8*b +: 8]   : en_q[8*b +: 8];
    assign ctrl_nx[8*b +: 8] = ctrl_we[b] ? ctrl_d[8*b +: 8] : ctrl_q[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= '0;
      en_q   <= '0;
      ctrl_q <= CTRL_RST;
      irq    <= 1'b0;
    end else begin
      sts_q  <= (sts_nx | hw_set) & STS_IMPL;
      en_q   <= en_nx & EN_IMPL;
      ctrl_q <= ctrl_nx & CTRL_IMPL;
      irq    <= (|(sts_q & en_q)) && ctrl_q[INT_EN_BIT];
    end
  end
endmodule

// File: rtl/pm_event_timer.sv
module pm_event_timer
  import pm_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 100_000_000,
  parameter longint unsigned TICK_HZ = 3_579_545,
  parameter int              ACC_W   = 32,
  parameter int              TMR_W   = 24,
  parameter int              ADDR_W  = 4,
  parameter int              DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [REG_W-1:0]  evt_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  logic [1:0]       sts_we, en_we, ctrl_we;
  logic [REG_W-1:0] sts_d, en_d, ctrl_d;
  logic [REG_W-1:0] sts_q, en_q, ctrl_q, hw_set;
  logic             tmr_load, tick, wrap;
  logic [TMR_W-1:0] tmr_d, count;
  logic [DATA_W-1:0] rd_mux;

  pm_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMR_W(TMR_W)) dec_i (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .sts_we(sts_we), .en_we(en_we), .ctrl_we(ctrl_we),
    .sts_d(sts_d), .en_d(en_d), .ctrl_d(ctrl_d),
    .tmr_load(tmr_load), .tmr_d(tmr_d)
  );

  pm_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .ACC_W(ACC_W)) tick_i (
    .clk(clk), .rst(rst), .tick(tick)
  );

  pm_timer #(.TMR_W(TMR_W)) tmr_i (
    .clk(clk), .rst(rst), .tick(tick), .load_en(tmr_load),
    .load_val(tmr_d), .count(count), .wrap(wrap)
  );

  assign hw_set = evt_in | (REG_W'(wrap) << TMR_OVF_BIT);

  pm_evt_regs regs_i (
    .clk(clk), .rst(rst),
    .sts_we(sts_we), .en_we(en_we), .ctrl_we(ctrl_we),
    .sts_d(sts_d), .en_d(en_d), .ctrl_d(ctrl_d),
    .hw_set(hw_set),
    .sts_q(sts_q), .en_q(en_q), .ctrl_q(ctrl_q), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    unique case (acc_size_e'(req_size))
      SZ_BYTE: begin
        case (req_addr)
          ADDR_W'(0): rd_mux = DATA_W'(sts_q[7:0]);
          ADDR_W'(1): rd_mux = DATA_W'(sts_q[15:8]);
          ADDR_W'(2): rd_mux = DATA_W'(en_q[7:0]);
          ADDR_W'(3): rd_mux = DATA_W'(en_q[15:8]);
          ADDR_W'(4): rd_mux = DATA_W'(ctrl_q[7:0]);
          ADDR_W'(5): rd_mux = DATA_W'(ctrl_q[15:8]);
          default: ;
        endcase
      end
      SZ_WORD: begin
        case (req_addr)
          ADDR_W'(0): rd_mux = DATA_W'(sts_q);
          ADDR_W'(2): rd_mux = DATA_W'(en_q);
          ADDR_W'(4): rd_mux = DATA_W'(ctrl_q);
          default: ;
        endcase
      end
      SZ_DWORD: begin
        case (req_addr)
          ADDR_W'(0): rd_mux = DATA_W'({en_q, sts_q});
          ADDR_W'(8): rd_mux = DATA_W'(count);
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pm_event_timer_chk.sv
module pm_event_timer_chk #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             tmr_load,
  input logic [TMR_W-1:0] tmr_d,
  input logic [TMR_W-1:0] count,
  input logic [15:0]      sts_q,
  input logic [15:0]      ctrl_q,
  input logic             irq,
  input logic             req_valid,
  input logic             req_write,
  input logic             rsp_valid
);
  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !tmr_load && (&count)) |=> (count == '0 && sts_q[0]));

  // R4
  timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !tmr_load) |=> $stable(count));

  // R4
  timer_load_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_load |=> (count == $past(tmr_d)));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctrl_q[0]));

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind pm_event_timer pm_event_timer_chk #(.TMR_W(TMR_W)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .tmr_load(tmr_load), .tmr_d(tmr_d),
  .count(count), .sts_q(sts_q), .ctrl_q(ctrl_q), .irq(irq),
  .req_valid(req_valid), .req_write(req_write), .rsp_valid(rsp_valid)
);

// File: tb/pm_event_timer_tb_top.sv
module pm_event_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [15:0] evt_in = '0;
  logic        rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  logic last_rv;

  localparam logic [15:0] STS_M = 16'h8D31, EN_M = 16'h0521, CTRL_M = 16'h3C05;

  always #5 clk = ~clk;

  pm_event_timer dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .evt_in(evt_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_size = s;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
    last_rv = rsp_valid;
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk); evt_in = v;
    @(negedge clk); evt_in = '0;
  endtask

  function automatic logic [15:0] w1c(input logic [15:0] cur, input logic [15:0] w);
    return cur & ~w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, t0, t1;
    logic [15:0] sts_m, en_m, ctrl_m;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    rd(0, 1, d); chk(d == 0, "R1 status", d, 0);
    chk(last_rv == 1, "R11 rsp_valid", 32'(last_rv), 1);
    @(negedge clk); chk(rsp_valid == 0, "R11 rsp one-cycle", 32'(rsp_valid), 0);
    rd(2, 1, d); chk(d == 0, "R1 enable", d, 0);
    rd(4, 1, d); chk(d == 32'h1, "R1 control", d, 1);
    rd(8, 2, d); chk(d <= 1, "R1 timer", d, 0);

    // R11 misaligned / out of range
    rd(1, 1, d); chk(d == 0, "R11 misaligned read", d, 0);
    rd(12, 2, d); chk(d == 0, "R11 out of range read", d, 0);
    wr(3, 1, 32'hFFFF);
    rd(2, 1, d); chk(d == 0, "R11 misaligned write enable", d, 0);
    rd(4, 1, d); chk(d == 1, "R11 misaligned write control", d, 1);

    // R4 timer load
    wr(8, 2, 32'hAB12_3456);
    rd(8, 2, d); chk(d == 32'h123456 || d == 32'h123457, "R4 load/upper byte zero", d, 32'h123456);
    wr(8, 1, 32'h0);
    rd(8, 2, d); chk(d >= 32'h123456 && d < 32'h123460, "R4 word write ignored", d, 32'h123456);

    // R2 rate
    rd(8, 2, t0);
    repeat (9998) @(negedge clk);
    rd(8, 2, t1);
    chk((t1 - t0) == 357 || (t1 - t0) == 358, "R2 tick rate", t1 - t0, 358);

    // R3 wrap
    wr(8, 2, 32'h00FF_FFFD);
    repeat (200) @(negedge clk);
    rd(8, 2, d); chk(d >= 1 && d <= 10, "R3 wrap count", d, 4);
    rd(0, 1, d); chk(d[0] == 1, "R3 overflow flag", d, 1);

    // R10 irq
    chk(irq == 0, "R10 irq masked", 32'(irq), 0);
    wr(2, 1, 32'h0001);
    @(negedge clk); chk(irq == 1, "R10 irq enabled", 32'(irq), 1);
    wr(4, 0, 32'h00);
    @(negedge clk); chk(irq == 0, "R10 irq gated off", 32'(irq), 0);
    wr(4, 0, 32'h01);
    @(negedge clk); chk(irq == 1, "R10 irq gated on", 32'(irq), 1);
    wr(0, 1, 32'h0001);
    @(negedge clk); chk(irq == 0, "R10 irq after clear", 32'(irq), 0);
    rd(0, 1, d); chk(d == 0, "R5 w1c bit0", d, 0);

    // R8 byte lanes
    wr(3, 0, 32'hFF);
    rd(2, 1, d); chk(d == 32'h0501, "R8 upper byte write", d, 32'h0501);
    wr(2, 0, 32'h00);
    rd(2, 1, d); chk(d == 32'h0500, "R8 lower byte write", d, 32'h0500);
    rd(3, 0, d); chk(d == 32'h05, "R8 upper byte read", d, 32'h05);

    // R7 control
    wr(4, 1, 32'hFFFF);
    rd(4, 1, d); chk(d == 32'h3C05, "R7 control implemented bits", d, 32'h3C05);
    wr(5, 0, 32'h00);
    rd(4, 1, d); chk(d == 32'h0005, "R7/R8 control upper byte", d, 32'h0005);
    wr(4, 1, 32'h0001);

    // R6 enable mask
    wr(2, 1, 32'hFFFF);
    rd(2, 1, d); chk(d == 32'h0521, "R6 enable implemented bits", d, 32'h0521);

    // R9 dword
    wr(0, 2, 32'h0000_FFFF);
    pulse(16'h0120);
    wr(0, 2, 32'hFFFF_0000);
    rd(0, 2, d); chk(d == 32'h0521_0120, "R9 dword write/read", d, 32'h0521_0120);
    wr(0, 2, 32'h0420_0000);
    rd(0, 2, d); chk(d == 32'h0420_0120, "R9 dword enable write", d, 32'h0420_0120);
    @(negedge clk); chk(irq == 1, "R10 irq from bit5", 32'(irq), 1);

    // R5 set beats clear
    wr(0, 1, 32'hFFFF);
    @(negedge clk);
    evt_in = 16'h0010; req_valid = 1; req_write = 1; req_addr = 0; req_size = 1; req_wdata = 32'h0010;
    @(negedge clk);
    evt_in = 0; req_valid = 0; req_write = 0;
    rd(0, 1, d); chk(d == 32'h0010, "R5 set wins over clear", d, 32'h0010);

    // R5/R6/R7 random
    sts_m = 16'h0010; en_m = 16'h0420; ctrl_m = 16'h0001;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] r, v;
      r = $urandom; v = $urandom;
      case (r[1:0])
        2'd0: begin pulse(v[15:0]); sts_m = sts_m | (v[15:0] & STS_M); end
        2'd1: begin wr(0, 1, {16'h0, v[15:0]}); sts_m = w1c(sts_m, v[15:0]); end
        2'd2: begin
          wr(4'(2 + r[2]), 0, {24'h0, v[7:0]});
          if (r[2]) en_m[15:8] = v[7:0] & EN_M[15:8];
          else      en_m[7:0]  = v[7:0] & EN_M[7:0];
        end
        default: begin wr(4, 1, {16'h0, v[15:0]}); ctrl_m = v[15:0] & CTRL_M; end
      endcase
      rd(0, 1, d); chk(d[15:0] == sts_m, "R5 random status", d, 32'(sts_m));
      rd(2, 1, d); chk(d[15:0] == en_m, "R6 random enable", d, 32'(en_m));
      rd(4, 1, d); chk(d[15:0] == ctrl_m, "R7 random control", d, 32'(ctrl_m));
      @(negedge clk);
      chk(irq == ((|(sts_m & en_m)) && ctrl_m[0]), "R10 random irq", 32'(irq),
          32'((|(sts_m & en_m)) && ctrl_m[0]));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule